// File: doc/BRIEF.md
# Queue-to-Channel Steering

This block decides, every clock cycle, which transmit queue may hand its next frame to which transmit DMA channel. Sixteen queues each hold a small configuration word: the channel the queue feeds, whether the queue is active, and a scheduler-acknowledge mode flag that is stored for the rest of the transmit path. Software writes and reads these words over a simple single-cycle register port. Each queue raises a request line when it has a frame ready. Each channel raises a ready line when it can accept one.

Several queues may point at the same channel. Queues that compete for one channel are served in round-robin order, with one pointer per channel. The channels themselves are ranked by a fixed priority in which a higher channel index always wins. The data channels rank background (0), best effort (1), video (2) and voice/management (3), and channel 7 is the command channel and ranks above all of them. The block grants at most one queue per cycle, combinationally, on the channel that wins.

Top module: `txq_steer`

## Requirements
- R1: After a synchronous active-low reset every queue word reads 0: channel 0, inactive, scheduler-ack off. With every request and every ready line high, no grant is issued while reset is held, and none is issued after reset until a queue is activated.
- R2: A write to queue `cfg_addr` stores `cfg_wdata[2:0]` as its channel, bit 3 as its active flag and bit 19 as its scheduler-ack flag. `cfg_rdata` shows the addressed word with those fields at the same positions and all other bits 0.
- R3: A grant on a channel is issued only while that channel's `ch_ready` bit is high.
- R4: A queue whose active flag is 0 is never granted, whatever its request line shows.
- R5: When `grant_valid` is high, the granted queue's request is high and `grant_channel` equals that queue's channel field.
- R6: Among channels that are ready and have at least one active requesting queue, the highest channel index is granted. Channel 7 (commands) therefore beats channel 3 (voice), channel 3 beats 2, 2 beats 1, and 1 beats 0.
- R7: Within one channel the grant goes to the first eligible queue at or after that channel's pointer, wrapping from 15 to 0. A grant moves the pointer to the granted queue + 1. Pointers of channels that issue no grant do not move. All pointers reset to 0.
- R8: With no eligible ready channel, `grant_valid` is 0 and `grant_queue` and `grant_channel` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the queue word at `cfg_addr` |
| cfg_addr | input | 4 | Queue index for write and read |
| cfg_wdata | input | 32 | Write data (channel 2:0, active 3, scheduler-ack 19) |
| cfg_rdata | output | 32 | Queue word at `cfg_addr` |
| q_req | input | 16 | Per-queue frame-ready request |
| ch_ready | input | 8 | Per-channel ability to accept a frame |
| grant_valid | output | 1 | A grant is issued this cycle |
| grant_queue | output | 4 | Granted queue index |
| grant_channel | output | 3 | Channel the grant is issued on |

## Verification
A corrupted queue word shows at once on `cfg_rdata` for that address. In the same cycle it also shows as a grant on the wrong channel, or as a grant to a queue that is not active. A round-robin pointer that slips or moves on the wrong channel does not show in the cycle it goes wrong. It shows at the next grant on that channel when two or more queues compete, so the bench compares every grant against a model of the pointers over long random runs. A fault in the priority stage shows in the same cycle as a lower channel winning over a ready higher one.

// File: rtl/txq_steer_pkg.sv
// Shared constants for the queue-to-channel steering block.
// Field positions of the per-queue configuration word are fixed here
// because software and the rest of the transmit path decode them.
package txq_steer_pkg;
    localparam int unsigned CFG_W    = 32;  // width of a queue word
    localparam int unsigned CH_LSB   = 0;   // channel field low bit
    localparam int unsigned CH_W     = 3;   // channel field width
    localparam int unsigned ACT_BIT  = 3;   // active flag
    localparam int unsigned SACK_BIT = 19;  // scheduler-ack enable
endpackage

// File: rtl/txq_cfg_regs.sv
// Per-queue configuration register file.
// Holds channel, active flag and scheduler-ack flag for each queue.
// Assumes single-cycle writes and a combinational read of the addressed word.
module txq_cfg_regs
    import txq_steer_pkg::*;
#(
    parameter int unsigned NUM_Q = 16,
    localparam int unsigned QW   = $clog2(NUM_Q)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [QW-1:0]         addr,
    input  logic [CFG_W-1:0]      wdata,
    output logic [CFG_W-1:0]      rdata,
    output logic [NUM_Q*CH_W-1:0] q_ch_flat,
    output logic [NUM_Q-1:0]      q_act
);
    logic [CH_W-1:0]  ch_r [NUM_Q];
    logic [NUM_Q-1:0] act_r;
    logic [NUM_Q-1:0] sack_r;

    // Store the fields of the addressed queue on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NUM_Q; q++) ch_r[q] <= '0;
            act_r  <= '0;
            sack_r <= '0;
        end else if (we) begin
            ch_r[addr]   <= wdata[CH_LSB +: CH_W];
            act_r[addr]  <= wdata[ACT_BIT];
            sack_r[addr] <= wdata[SACK_BIT];
        end
    end

    // Rebuild the addressed word; unused bits read as zero.
    always_comb begin
        rdata                 = '0;
        rdata[CH_LSB +: CH_W] = ch_r[addr];
        rdata[ACT_BIT]        = act_r[addr];
        rdata[SACK_BIT]       = sack_r[addr];
    end

    // Flatten channel fields for the steering logic.
    for (genvar g = 0; g < NUM_Q; g++) begin : g_flat
        assign q_ch_flat[g*CH_W +: CH_W] = ch_r[g];
    end
    assign q_act = act_r;
endmodule

// File: rtl/txq_rr_pick.sv
// Round-robin picker for the queues competing for one channel.
// Scans cyclically from its pointer; a grant moves the pointer past the winner.
// Assumes 'adv' is only raised while 'found' is high.
module txq_rr_pick #(
    parameter int unsigned NUM_Q = 16,
    localparam int unsigned QW   = $clog2(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] elig,
    input  logic             adv,
    output logic             found,
    output logic [QW-1:0]    pick
);
    logic [QW-1:0] ptr;

    // Find the first eligible queue at or after the pointer, wrapping.
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < NUM_Q; k++) begin
            idx = int'(ptr) + k;
            if (idx >= int'(NUM_Q)) idx = idx - int'(NUM_Q);
            if (!found && elig[idx]) begin
                found = 1'b1;
                pick  = QW'(idx);
            end
        end
    end

    // Move the pointer to the queue after the granted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (int'(pick) == int'(NUM_Q) - 1) ? '0 : pick + 1'b1;
        end
    end
endmodule

// File: rtl/txq_ch_prio.sv
// Fixed-priority channel selector: the highest index with a pending,
// ready channel wins. Purely combinational.
module txq_ch_prio #(
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned CHW   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] avail,
    output logic              valid,
    output logic [CHW-1:0]    sel
);
    // Later (higher) channels overwrite earlier ones.
    always_comb begin
        valid = 1'b0;
        sel   = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (avail[c]) begin
                valid = 1'b1;
                sel   = CHW'(c);
            end
        end
    end
endmodule

// File: rtl/txq_steer.sv
// Queue-to-transmit-channel steering, top level.
// Filters requests by active flag and channel binding, runs one round-robin
// picker per channel, then grants the highest ready channel with a winner.
// Assumes the channel field width matches $clog2(NUM_CH).
module txq_steer
    import txq_steer_pkg::*;
#(
    parameter int unsigned NUM_Q  = 16,
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned QW    = $clog2(NUM_Q),
    localparam int unsigned CHW   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QW-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [NUM_Q-1:0]  q_req,
    input  logic [NUM_CH-1:0] ch_ready,
    output logic              grant_valid,
    output logic [QW-1:0]     grant_queue,
    output logic [CHW-1:0]    grant_channel
);
    logic [NUM_Q*CH_W-1:0] q_ch_flat;
    logic [NUM_Q-1:0]      q_act;
    logic [NUM_CH-1:0]     ch_found;
    logic [NUM_CH-1:0]     ch_avail;
    logic [QW-1:0]         ch_pick [NUM_CH];
    logic                  sel_valid;
    logic [CHW-1:0]        sel_ch;

    txq_cfg_regs #(.NUM_Q(NUM_Q)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .q_ch_flat (q_ch_flat),
        .q_act     (q_act)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_Q-1:0] elig;
        logic             adv;

        // Queues that are active, requesting and bound to this channel.
        always_comb begin
            for (int q = 0; q < NUM_Q; q++) begin
                elig[q] = q_req[q] && q_act[q] &&
                          (q_ch_flat[q*CH_W +: CH_W] == CH_W'(c));
            end
        end

        assign adv         = sel_valid && (sel_ch == CHW'(c));
        assign ch_avail[c] = ch_found[c] && ch_ready[c];

        txq_rr_pick #(.NUM_Q(NUM_Q)) u_rr (
            .clk   (clk),
            .rst_n (rst_n),
            .elig  (elig),
            .adv   (adv),
            .found (ch_found[c]),
            .pick  (ch_pick[c])
        );
    end

    txq_ch_prio #(.NUM_CH(NUM_CH)) u_prio (
        .avail (ch_avail),
        .valid (sel_valid),
        .sel   (sel_ch)
    );

    // Drive the grant; fields idle at zero without a winner.
    always_comb begin
        grant_valid   = sel_valid;
        grant_channel = sel_valid ? sel_ch : '0;
        grant_queue   = sel_valid ? ch_pick[sel_ch] : '0;
    end
endmodule

// File: rtl/txq_steer_chk.sv
// Assertion checker for txq_steer, attached by bind below.
// Recomputes channel availability from ports and register-file outputs.
module txq_steer_chk #(
    parameter int unsigned NUM_Q  = 16,
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned QW     = 4,
    parameter int unsigned CHW    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_Q-1:0]  q_req,
    input logic [NUM_CH-1:0] ch_ready,
    input logic [NUM_Q-1:0]  q_act,
    input logic [NUM_Q*CHW-1:0] q_ch_flat,
    input logic              grant_valid,
    input logic [QW-1:0]     grant_queue,
    input logic [CHW-1:0]    grant_channel
);
    logic [NUM_CH-1:0] avail;
    logic              higher;

    // Channels that are ready and have an active requesting queue.
    always_comb begin
        avail = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (q_req[q] && q_act[q] && ch_ready[q_ch_flat[q*CHW +: CHW]])
                avail[q_ch_flat[q*CHW +: CHW]] = 1'b1;
        end
        higher = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (c > int'(grant_channel) && avail[c]) higher = 1'b1;
        end
    end

    a_r3_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ch_ready[grant_channel]);

    a_r4_active_only: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> q_act[grant_queue]);

    a_r5_bound_channel: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (q_req[grant_queue] &&
                         q_ch_flat[grant_queue*CHW +: CHW] == grant_channel));

    a_r6_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !higher);

    a_r8_idle_when_none: assert property (@(posedge clk) disable iff (!rst_n)
        (avail == '0) |-> (!grant_valid && grant_queue == '0 && grant_channel == '0));

    a_r1_no_grant_reset: assert property (@(posedge clk)
        !rst_n |-> !grant_valid || $past(rst_n));
endmodule

bind txq_steer txq_steer_chk #(
    .NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .QW(QW), .CHW(CHW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .q_req         (q_req),
    .ch_ready      (ch_ready),
    .q_act         (q_act),
    .q_ch_flat     (q_ch_flat),
    .grant_valid   (grant_valid),
    .grant_queue   (grant_queue),
    .grant_channel (grant_channel)
);

// File: tb/txq_steer_tb_top.sv
// Self-checking bench for txq_steer: directed corners plus seeded random traffic
// compared against a requirement-level model of registers and pointers.
module txq_steer_tb_top;
    localparam int NQ = 16;
    localparam int NC = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [15:0] q_req;
    logic [7:0]  ch_ready;
    logic        grant_valid;
    logic [3:0]  grant_queue;
    logic [2:0]  grant_channel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Model state
    logic [2:0] m_ch   [NQ];
    logic       m_act  [NQ];
    logic       m_sack [NQ];
    int         m_ptr  [NC];

    always #4 clk = ~clk;  // 125 MHz

    txq_steer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .q_req(q_req),
        .ch_ready(ch_ready), .grant_valid(grant_valid),
        .grant_queue(grant_queue), .grant_channel(grant_channel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) begin
            m_ch[q] = '0; m_act[q] = 1'b0; m_sack[q] = 1'b0;
        end
        for (int c = 0; c < NC; c++) m_ptr[c] = 0;
    endtask

    function automatic logic [31:0] word_of(input int q);
        return (32'(m_sack[q]) << 19) | (32'(m_act[q]) << 3) | 32'(m_ch[q]);
    endfunction

    // Expected grant from the requirements: highest ready channel, RR inside.
    function automatic void expect_grant(input logic [15:0] req, input logic [7:0] rdy,
                                         output bit ev, output int eq, output int ec);
        ev = 0; eq = 0; ec = 0;
        for (int c = NC - 1; c >= 0; c--) begin
            if (!ev && rdy[c]) begin
                for (int k = 0; k < NQ; k++) begin
                    int q;
                    q = (m_ptr[c] + k) % NQ;
                    if (!ev && req[q] && m_act[q] && m_ch[q] == 3'(c)) begin
                        ev = 1; eq = q; ec = c;
                    end
                end
            end
        end
    endfunction

    // One cycle: drive, check grant, then account for the clock edge.
    task automatic cycle(input logic [15:0] req, input logic [7:0] rdy, input bit we,
                         input logic [3:0] addr, input logic [31:0] wd, input string tag);
        bit ev; int eq; int ec;
        @(negedge clk);
        q_req = req; ch_ready = rdy; cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
        #1;
        expect_grant(req, rdy, ev, eq, ec);
        check({tag, " valid"}, 32'(grant_valid), 32'(ev));
        check({tag, " queue"}, 32'(grant_queue), 32'(eq));
        check({tag, " channel"}, 32'(grant_channel), 32'(ec));
        if (we) begin
            m_ch[addr] = wd[2:0]; m_act[addr] = wd[3]; m_sack[addr] = wd[19];
        end
        if (ev) m_ptr[ec] = (eq + 1) % NQ;
    endtask

    task automatic wr(input int q, input logic [31:0] wd);
        cycle(16'h0, 8'h0, 1'b1, 4'(q), wd, "R2 write");
    endtask

    task automatic rd(input int q, input string tag);
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 4'(q); q_req = '0;
        #1;
        check(tag, cfg_rdata, word_of(q));
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        q_req = '1; ch_ready = '1;
        model_reset();
        // R1: no grant while reset is held even with all lines high
        repeat (3) begin
            @(negedge clk); #1;
            check("R1 grant in reset", 32'(grant_valid), 32'h0);
        end
        @(negedge clk); rst_n = 1'b1;
        for (int q = 0; q < NQ; q++) rd(q, "R1 reset word");
        cycle(16'hFFFF, 8'hFF, 1'b0, 4'h0, 32'h0, "R1 no grant after reset");

        // R2: field placement, reserved bits zero
        wr(5, 32'hFFFF_FFFF);
        rd(5, "R2 all-ones readback");
        check("R2 literal word", cfg_rdata, 32'h0008_000F);
        wr(5, 32'h0000_0006);
        rd(5, "R2 inactive ch6");

        // R4: inactive queue on ready channel is never granted
        cycle(16'h0020, 8'hFF, 1'b0, 4'h0, 32'h0, "R4 inactive ignored");
        check("R4 no grant", 32'(grant_valid), 32'h0);

        // R7: three active queues share channel 1
        wr(1, 32'h9); wr(4, 32'h9); wr(9, 32'h9);
        for (int i = 0; i < 7; i++)
            cycle(16'h0212, 8'h02, 1'b0, 4'h0, 32'h0, "R7 round robin");
        // R3: channel not ready blocks grant, pointer holds
        cycle(16'h0212, 8'hFD, 1'b0, 4'h0, 32'h0, "R3 not ready");
        check("R3 no grant", 32'(grant_valid), 32'h0);
        cycle(16'h0212, 8'h02, 1'b0, 4'h0, 32'h0, "R7 pointer held");

        // R6: command channel 7 beats voice channel 3, 3 beats 1
        wr(12, 32'hF); wr(13, 32'hB);
        cycle(16'h3212, 8'hFF, 1'b0, 4'h0, 32'h0, "R6 command wins");
        check("R6 command queue", 32'(grant_queue), 32'd12);
        cycle(16'h2212, 8'h7F, 1'b0, 4'h0, 32'h0, "R6 voice over best effort");
        check("R6 voice channel", 32'(grant_channel), 32'd3);
        // R8: idle output fields
        cycle(16'h0000, 8'hFF, 1'b0, 4'h0, 32'h0, "R8 idle");
        check("R8 idle queue", 32'(grant_queue), 32'h0);

        // Random traffic against the model (R3 R4 R5 R6 R7)
        for (int i = 0; i < 4000; i++) begin
            bit we; logic [31:0] wd; logic [7:0] rdy;
            we = ($urandom % 6) == 0;
            wd = $urandom;
            rdy = 8'($urandom) | 8'($urandom);
            cycle(16'($urandom), rdy, we, 4'($urandom), wd, "R5 R6 R7 random");
        end
        for (int q = 0; q < NQ; q++) rd(q, "R2 final readback");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule